// File: doc/BRIEF.md
# CORDIC Rotator Frequency Shifter

This block shifts a complex sample stream in frequency without multipliers or a sine table. A phase accumulator grows by a signed tuning word for every accepted sample. Each I/Q pair is rotated by the accumulator's current angle in an unrolled shift-and-add rotation pipeline. A positive word rotates counterclockwise and moves the spectrum up. A negative word moves it down, so the same block acts as the mixer of a receive or a transmit chain.

The top two bits of the angle pick a coarse turn of 0, 90, 180 or 270 degrees. That turn is applied by swapping and negating I and Q. The remaining angle, below 90 degrees, goes to sixteen micro-rotation stages. Each stage steers by the sign of the angle still left to rotate. The vector length grows by a fixed factor through the stages, and a last stage removes it with a constant built from shifts, then rounds and clamps the result to the output width.

Both streams use valid/ready. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. When a result waits with `out_ready` low, the whole pipeline freezes, `in_ready` drops and the waiting result stays unchanged. The block never drops or duplicates a sample.

Top module: `cordic_freq_shifter`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. A sample enters only on an edge with `in_valid` and `in_ready` both high. Every accepted sample produces exactly one result, in acceptance order.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_i` and `out_q` hold their values on the next edge.
- R3: The n-th accepted sample after reset uses phase P(n), where P(0) = 0 and P(n+1) = P(n) + `freq_word` mod 2^32. `freq_word` is sampled on the edge that accepts sample n. The angle is θ = 2π·P/2^32, and the results are out_i = I·cosθ − Q·sinθ and out_q = I·sinθ + Q·cosθ.
- R4: Results are within 4 LSB of R3 in all four quadrants of θ. Bits 31:30 of the phase select the coarse turn. The angle left after the last stage stays near zero.
- R5: With a zero tuning word the output equals the input within 4 LSB, so the gain of the stages is removed.
- R6: A result beyond the signed 16-bit range is clamped to 32767 or −32768.
- R7: With `out_ready` held high, a sample accepted on edge k appears with `out_valid` high after edge k+17, which is a latency of 18 edges.
- R8: During reset `out_valid` is low. After reset the phase restarts at zero.
- R9: Edges on which no sample is accepted leave the phase unchanged, whatever `freq_word` holds then.
- R10: A negative tuning word rotates clockwise. A tone at +F mixed with −F comes out at DC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_i | input | 16 | Input in-phase, signed |
| in_q | input | 16 | Input quadrature, signed |
| freq_word | input | 32 | Signed phase step per accepted sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_i | output | 16 | Rotated in-phase, signed |
| out_q | output | 16 | Rotated quadrature, signed |

## Verification
The hardest case to reach from the ports is a stall that lands while results from several different phase steps are still in the pipeline. Only then does a frozen stage that forgot its angle or its valid bit show up. The stimulus uses two irregular `out_ready` patterns and a new tuning word on every sample, and it inserts idle gaps in which `freq_word` is changed to noise. A second reset followed by 45-degree steps on a full-scale input lands the rotated vector on both clamp limits at a known phase.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int ATAN_TABLE_LEN = 24;

  // arctan(2^-idx) expressed as a fraction of a full turn, scaled by 2^32
  function automatic logic [31:0] atan_turn32(input int idx);
    case (idx)
      0:  return 32'd536870912;
      1:  return 32'd316933406;
      2:  return 32'd167458907;
      3:  return 32'd85004756;
      4:  return 32'd42667331;
      5:  return 32'd21354465;
      6:  return 32'd10679838;
      7:  return 32'd5340245;
      8:  return 32'd2670163;
      9:  return 32'd1335087;
      10: return 32'd667544;
      11: return 32'd333772;
      12: return 32'd166886;
      13: return 32'd83443;
      14: return 32'd41722;
      15: return 32'd20861;
      16: return 32'd10430;
      17: return 32'd5215;
      18: return 32'd2608;
      19: return 32'd1304;
      20: return 32'd652;
      21: return 32'd326;
      22: return 32'd163;
      23: return 32'd81;
      default: return 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/cfs_phase_acc.sv
module cfs_phase_acc #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [PW-1:0] incr,
  output logic [PW-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (step) phase <= phase + incr;
  end
endmodule

// File: rtl/cfs_prerotate.sv
module cfs_prerotate #(
  parameter int DW = 16,
  parameter int XW = 22,
  parameter int ZW = 24,
  parameter int FB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [ZW-1:0]        phase_top,
  output logic                 vld_o,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  logic signed [XW-1:0] xe, ye, xr, yr;
  logic signed [ZW-1:0] resid;
  logic [1:0]           quad;

  assign xe    = XW'(in_i) <<< FB;
  assign ye    = XW'(in_q) <<< FB;
  assign quad  = phase_top[ZW-1:ZW-2];
  assign resid = {2'b00, phase_top[ZW-3:0]};

  // coarse turn by a multiple of 90 degrees, counterclockwise
  always_comb begin
    case (quad)
      2'd0:    begin xr = xe;  yr = ye;  end
      2'd1:    begin xr = -ye; yr = xe;  end
      2'd2:    begin xr = -xe; yr = -ye; end
      default: begin xr = ye;  yr = -xe; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      x_o   <= '0;
      y_o   <= '0;
      z_o   <= '0;
    end else if (adv) begin
      vld_o <= vld_i;
      x_o   <= xr;
      y_o   <= yr;
      z_o   <= resid;
    end
  end
endmodule

// File: rtl/cfs_cordic_stage.sv
module cfs_cordic_stage #(
  parameter int XW  = 22,
  parameter int ZW  = 24,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 vld_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 vld_o,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  localparam logic [31:0] TURN = cfs_pkg::atan_turn32(IDX);
  localparam logic [32:0] HALF = 33'(1) << (31 - ZW);
  localparam logic [32:0] SUMV = {1'b0, TURN} + HALF;
  localparam logic signed [ZW-1:0] ANG = ZW'(SUMV >> (32 - ZW));

  logic signed [XW-1:0] xs, ys;
  logic                 dpos;

  assign xs   = x_i >>> IDX;
  assign ys   = y_i >>> IDX;
  assign dpos = ~z_i[ZW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      x_o   <= '0;
      y_o   <= '0;
      z_o   <= '0;
    end else if (adv) begin
      vld_o <= vld_i;
      if (dpos) begin
        x_o <= x_i - ys;
        y_o <= y_i + xs;
        z_o <= z_i - ANG;
      end else begin
        x_o <= x_i + ys;
        y_o <= y_i - xs;
        z_o <= z_i + ANG;
      end
    end
  end
endmodule

// File: rtl/cfs_gain_sat.sv
module cfs_gain_sat #(
  parameter int DW = 16,
  parameter int XW = 22,
  parameter int FB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 vld_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  output logic                 vld_o,
  output logic signed [DW-1:0] i_o,
  output logic signed [DW-1:0] q_o
);
  localparam int WW = XW + 16;
  localparam int SH = FB + 16;
  localparam logic signed [WW-1:0] RND  = WW'(1) <<< (SH - 1);
  localparam logic signed [WW-1:0] MAXV = (WW'(1) <<< (DW - 1)) - WW'(1);
  localparam logic signed [WW-1:0] MINV = -(WW'(1) <<< (DW - 1));

  // multiply by about 0.607254 (inverse of the stage gain) with shifts
  function automatic logic signed [DW-1:0] scale_sat(input logic signed [XW-1:0] v);
    logic signed [WW-1:0] w, acc;
    w   = WW'(v) <<< 16;
    acc = (w >>> 1) + (w >>> 3) - (w >>> 6) - (w >>> 9)
        - (w >>> 13) - (w >>> 15) - (w >>> 16);
    acc = (acc + RND) >>> SH;
    if (acc > MAXV)      return DW'(MAXV);
    else if (acc < MINV) return DW'(MINV);
    else                 return DW'(acc);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      i_o   <= '0;
      q_o   <= '0;
    end else if (adv) begin
      vld_o <= vld_i;
      i_o   <= scale_sat(x_i);
      q_o   <= scale_sat(y_i);
    end
  end
endmodule

// File: rtl/cordic_freq_shifter.sv
module cordic_freq_shifter #(
  parameter int DW     = 16,
  parameter int PW     = 32,
  parameter int ZW     = 24,
  parameter int STAGES = 16,
  parameter int GUARD  = 2,
  parameter int FB     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic signed [PW-1:0] freq_word,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int XW = DW + GUARD + FB;

  if (STAGES < 1 || STAGES > cfs_pkg::ATAN_TABLE_LEN) begin : g_bad_stages
    $error("STAGES out of range");
  end
  if (ZW < 4 || ZW > 31 || ZW > PW) begin : g_bad_zw
    $error("ZW out of range");
  end

  logic adv, accept;
  logic [PW-1:0] phase_q;

  logic [STAGES:0]      vld_s;
  logic signed [XW-1:0] x_s [0:STAGES];
  logic signed [XW-1:0] y_s [0:STAGES];
  logic signed [ZW-1:0] z_s [0:STAGES];

  assign adv      = ~out_valid | out_ready;
  assign in_ready = adv;
  assign accept   = in_valid & adv;

  cfs_phase_acc #(.PW(PW)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (accept),
    .incr  (freq_word),
    .phase (phase_q)
  );

  cfs_prerotate #(.DW(DW), .XW(XW), .ZW(ZW), .FB(FB)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .vld_i     (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .phase_top (phase_q[PW-1 -: ZW]),
    .vld_o     (vld_s[0]),
    .x_o       (x_s[0]),
    .y_o       (y_s[0]),
    .z_o       (z_s[0])
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    cfs_cordic_stage #(.XW(XW), .ZW(ZW), .IDX(s)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .vld_i (vld_s[s]),
      .x_i   (x_s[s]),
      .y_i   (y_s[s]),
      .z_i   (z_s[s]),
      .vld_o (vld_s[s+1]),
      .x_o   (x_s[s+1]),
      .y_o   (y_s[s+1]),
      .z_o   (z_s[s+1])
    );
  end

  cfs_gain_sat #(.DW(DW), .XW(XW), .FB(FB)) u_gain (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .vld_i (vld_s[STAGES]),
    .x_i   (x_s[STAGES]),
    .y_i   (y_s[STAGES]),
    .vld_o (out_valid),
    .i_o   (out_i),
    .q_o   (out_q)
  );
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
  parameter int DW     = 16,
  parameter int PW     = 32,
  parameter int ZW     = 24,
  parameter int STAGES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic [PW-1:0]        freq_word,
  input logic [PW-1:0]        phase,
  input logic                 vld_end,
  input logic signed [ZW-1:0] z_end
);
  localparam logic [31:0] LAST_TURN = cfs_pkg::atan_turn32(STAGES - 1);
  localparam int BOUND = int'(LAST_TURN >> (32 - ZW)) + STAGES;
  localparam logic signed [ZW-1:0] ZB = ZW'(BOUND);

  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r2_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_i) && $stable(out_q));

  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> phase == $past(phase) + $past(freq_word));

  a_r9_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(phase));

  a_r4_angle_converged: assert property (@(posedge clk) disable iff (!rst_n)
    vld_end |-> (z_end <= ZB) && (z_end >= -ZB));
endmodule

bind cordic_freq_shifter cfs_checker #(
  .DW(DW), .PW(PW), .ZW(ZW), .STAGES(STAGES)
) u_cfs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_i     (out_i),
  .out_q     (out_q),
  .freq_word (freq_word),
  .phase     (phase_q),
  .vld_end   (vld_s[STAGES]),
  .z_end     (z_s[STAGES])
);

// File: tb/test_cordic_freq_shifter.sv
`timescale 1ns/1ps
module test_cordic_freq_shifter;
  localparam int DW  = 16;
  localparam int LAT = 18;
  localparam int TOL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic signed [31:0]   freq_word = '0;
  logic signed [DW-1:0] out_i, out_q;

  always #10 clk = ~clk;

  cordic_freq_shifter i_cordic_freq_shifter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .freq_word(freq_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  int n_checks = 0;
  int n_fail = 0;
  int ready_mode = 0;
  int exp_i_q[$];
  int exp_q_q[$];
  string tag_q[$];
  logic [31:0] model_phase = '0;

  task automatic check(string req, int act, int exp, int tol);
    int diff;
    n_checks++;
    diff = act - exp;
    if (diff < 0) diff = -diff;
    if (diff > tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int round_sat(real v);
    int r;
    r = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic push_expect(int i, int q, logic [31:0] ph, string req);
    real th, ei, eq;
    th = real'(ph) * 6.283185307179586 / 4294967296.0;
    ei = real'(i) * $cos(th) - real'(q) * $sin(th);
    eq = real'(i) * $sin(th) + real'(q) * $cos(th);
    exp_i_q.push_back(round_sat(ei));
    exp_q_q.push_back(round_sat(eq));
    tag_q.push_back(req);
  endtask

  // driver: one sample, waits for acceptance, records expected result
  task automatic send(int i, int q, logic [31:0] fw, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = DW'(i);
    in_q = DW'(q);
    freq_word = fw;
    #8;
    while (!in_ready) begin
      @(negedge clk);
      #8;
    end
    push_expect(i, q, model_phase, req);
    model_phase = model_phase + fw;
  endtask

  task automatic idle(int n, logic [31:0] noise);
    @(negedge clk);
    in_valid = 1'b0;
    freq_word = noise;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 400 && exp_i_q.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R1 queue empty after drain", exp_i_q.size(), 0, 0);
  endtask

  // monitor: drives out_ready, pops and compares, checks hold under stall
  initial begin
    int cyc;
    bit prev_stall;
    int prev_i, prev_q;
    cyc = 0;
    prev_stall = 0;
    prev_i = 0;
    prev_q = 0;
    forever begin
      @(negedge clk);
      case (ready_mode)
        1:       out_ready = (cyc % 3) != 0;
        2:       out_ready = (cyc % 7) < 2;
        default: out_ready = 1'b1;
      endcase
      cyc++;
      #8;
      if (rst_n && prev_stall) begin
        check("R2 valid held", int'(out_valid), 1, 0);
        check("R2 out_i held", int'(out_i), prev_i, 0);
        check("R2 out_q held", int'(out_q), prev_q, 0);
      end
      prev_stall = rst_n && out_valid && !out_ready;
      prev_i = int'(out_i);
      prev_q = int'(out_q);
      if (rst_n && out_valid && out_ready) begin
        if (exp_i_q.size() == 0) begin
          check("R1 no extra result", 1, 0, 0);
        end else begin
          int ei, eq;
          string t;
          ei = exp_i_q.pop_front();
          eq = exp_q_q.pop_front();
          t = tag_q.pop_front();
          check({t, " out_i"}, int'(out_i), ei, TOL);
          check({t, " out_q"}, int'(out_q), eq, TOL);
        end
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    int edges;
    real w;
    logic [31:0] tone;
    // R8: reset state
    repeat (3) @(negedge clk);
    #8;
    check("R8 out_valid low in reset", int'(out_valid), 0, 0);
    check("R1 in_ready high in reset", int'(in_ready), 1, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: latency on an empty pipeline
    ready_mode = 0;
    send(12000, -7000, 32'd0, "R5 zero word");
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid && edges < 60) begin
      @(posedge clk);
      edges++;
      #1;
    end
    check("R7 latency", edges, LAT, 0);
    drain();

    // R5: unit gain at zero phase
    send(1000, 0, 32'd0, "R5 zero word");
    send(-20000, 12000, 32'd0, "R5 zero word");
    send(-31000, -25, 32'd0, "R5 zero word");
    send(3, -3, 32'd0, "R5 zero word");
    drain();

    // R4: sweep phase through all quadrants back to back
    for (int k = 0; k < 48; k++)
      send(20000 - k * 700, -15000 + k * 600, 32'h0B2C_4F37, "R4 quadrant sweep");
    drain();

    // R10: tone at +F mixed with -F
    tone = 32'h0345_6789;
    w = real'(tone) * 6.283185307179586 / 4294967296.0;
    for (int k = 0; k < 24; k++)
      send(round_sat(20000.0 * $cos(w * k)), round_sat(20000.0 * $sin(w * k)),
           -tone, "R10 negative word");
    drain();

    // R2/R3: back-pressure with a new word every sample
    ready_mode = 1;
    for (int k = 0; k < 30; k++)
      send(9000 + k * 313, -4000 - k * 271, 32'h1357_9BDF + k * 32'h0101_0101, "R3 per-sample word");
    drain();
    ready_mode = 2;
    for (int k = 0; k < 30; k++) begin
      send(-15000 + k * 911, 22000 - k * 555, 32'hF0F0_1234 - k * 32'h0033_0000, "R3 stall pattern");
      if (k % 5 == 4) idle(3, 32'h7777_0000 + k);
    end
    drain();

    // R9: idle gaps with noise on the word
    ready_mode = 0;
    for (int k = 0; k < 10; k++) begin
      send(17000, 5000 - k * 1000, 32'h2222_0000, "R9 idle keeps phase");
      idle(2 + k % 3, 32'hDEAD_0000 + k);
    end
    drain();

    // R6 and R8: second reset, then 45-degree steps at full scale
    @(negedge clk);
    rst_n = 1'b0;
    model_phase = '0;
    repeat (2) @(negedge clk);
    #8;
    check("R8 out_valid low in second reset", int'(out_valid), 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++)
      send(32767, 32767, 32'h2000_0000, "R6 clamp");
    for (int k = 0; k < 8; k++)
      send(-32768, -32768, 32'h2000_0000, "R6 clamp");
    drain();

    report();
    $finish;
  end
endmodule